// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable synchronous static RAM with registered inputs. The bus can turn from read to write, or back, on consecutive cycles with no idle cycle. Reads and writes share one pipeline depth. A read returns its word two active clock edges after its address is sampled. A write takes its data from the data input two active edges after its address. Because of this, a read issued right after a write to the same word must receive the newer bytes. The block forwards them lane by lane.

The default array holds 256 words of 36 bits, split into four 9-bit lanes. A load cycle starts an access at an external address. Continue cycles then walk the two low address bits in one of two orders, chosen by a static mode pin. The other inputs are:
- a clock-stall input
- a three-pin select
- an asynchronous output enable
- a sleep input with a two-edge entry and a two-edge exit

The bidirectional data bus appears as separate data-in, data-out and drive-enable signals.

Top module: `zt_burst_sram`

## Requirements
- R1: While `rst` is high and after it is released, `dout_en` is low and no access is pending.
- R2: A read sampled on an active edge drives `dout` with the array word, and raises `dout_en`, just after the second active edge that follows. Reads and writes may alternate on every cycle with no idle cycle.
- R3: `lane_wr_n[i]` low writes bits [9i+8:9i] of a word. A write whose strobes are all high is accepted but leaves the array unchanged.
- R4: A read issued on the cycle after a write to the same address returns the written lanes from `din` merged with the old contents of the other lanes.
- R5: With `order_xor`=1, the n-th continue after a load at start address S accesses address bits [1:0] = S[1:0] XOR n (n taken modulo 4). Bits [7:2] keep the loaded value.
- R6: With `order_xor`=0, the n-th continue accesses address bits [1:0] = (S[1:0] + n) mod 4. The upper bits keep the loaded value.
- R7: A load cycle selects the block only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: no data is driven and no write happens.
- R8: Continue cycles that follow a deselect, or that follow reset, stay deselected.
- R9: An edge with `stall` high changes no state: pipeline, burst position, array and outputs all hold.
- R10: `oe_n` high forces `dout_en` low at once, whatever the pipeline holds.
- R11: `sleep` sampled high on two edges puts the block to sleep. While asleep, `dout_en` is low and commands are ignored. Two low samples wake it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | High: the edge is ignored entirely |
| sel_a_n | input | 1 | Select term, active low |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| burst_cont | input | 1 | 0: load a new address, 1: continue the burst |
| wr_n | input | 1 | 0: write access, 1: read access (load cycles) |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| order_xor | input | 1 | Burst order: 1 XOR, 0 linear; static |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request |
| addr | input | 8 | Word address |
| din | input | 36 | Write data, taken two active edges after its address |
| dout | output | 36 | Read data |
| dout_en | output | 1 | High when the block drives `dout` onto the bus |

## Verification
The bench first fills the array with single writes and reads it back, which fixes the latency and the data path. Partial-strobe and all-high-strobe writes show whether each lane is gated on its own. Write-then-read pairs to one address separate correct forwarding from a stale array read. Four-beat bursts from odd start addresses in both modes expose any confusion between XOR and linear stepping. Select patterns, continues after deselects, stalls, output-enable pulses and a sleep episode each target one control path. A long random mix of all of these then runs against the behavioural reference, and every cycle is compared.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sleep_sync.sv
module zt_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic asleep
);
  logic [STAGES-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[STAGES-2:0], sleep};
  end

  assign asleep = hist[STAGES-1];
endmodule

// File: rtl/zt_cmd_front.sv
module zt_cmd_front
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int LANES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              sel,
  input  logic              burst_cont,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_be_n
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               act_q, wr_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] start_q, cnt_q;
  logic [BURST_W-1:0] cnt_nx, lo_nx;

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    lo_nx  = order_xor ? (start_q ^ cnt_nx) : (start_q + cnt_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      wr_q     <= 1'b0;
      hi_q     <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      iss_op   <= OP_NONE;
      iss_addr <= '0;
      iss_be_n <= '1;
    end else if (go) begin
      iss_be_n <= lane_wr_n;
      if (!burst_cont) begin
        if (sel) begin
          act_q    <= 1'b1;
          wr_q     <= !wr_n;
          hi_q     <= addr[ADDR_W-1:BURST_W];
          start_q  <= addr[BURST_W-1:0];
          cnt_q    <= '0;
          iss_op   <= wr_n ? OP_READ : OP_WRITE;
          iss_addr <= addr;
        end else begin
          act_q  <= 1'b0;
          iss_op <= OP_NONE;
        end
      end else if (act_q) begin
        cnt_q    <= cnt_nx;
        iss_op   <= wr_q ? OP_WRITE : OP_READ;
        iss_addr <= {hi_q, lo_nx};
      end else begin
        iss_op <= OP_NONE;
      end
    end
  end
endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [LANES-1:0]        s1_be_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic                    rd_vld,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int W     = LANES * LANE_W;

  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_be_n;
  logic [W-1:0]      raw_q, fwd_q;
  logic [LANES-1:0]  fwd_mask_q;
  logic              hit;

  assign hit = (s2_op == OP_WRITE) && (s1_op == OP_READ) && (s2_addr == s1_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op      <= OP_NONE;
      s2_addr    <= '0;
      s2_be_n    <= '1;
      fwd_mask_q <= '0;
      fwd_q      <= '0;
    end else if (go) begin
      s2_op      <= s1_op;
      s2_addr    <= s1_addr;
      s2_be_n    <= s1_be_n;
      fwd_q      <= din;
      fwd_mask_q <= hit ? ~s2_be_n : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_vld <= 1'b0;
    else if (go) rd_vld <= (s2_op == OP_READ);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (go) begin
        if (s2_op == OP_WRITE && !s2_be_n[l])
          mem[s2_addr] <= din[l*LANE_W +: LANE_W];
        raw_q[l*LANE_W +: LANE_W] <= mem[s1_addr];
      end
    end

    always_ff @(posedge clk) begin
      if (go && s2_op == OP_READ)
        rd_data[l*LANE_W +: LANE_W] <= fwd_mask_q[l] ? fwd_q[l*LANE_W +: LANE_W]
                                                     : raw_q[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  parameter int SLEEP_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stall,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    burst_cont,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    order_xor,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  logic              asleep, go, sel, rd_vld;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_be_n;

  assign sel = !sel_a_n && sel_b && !sel_c_n;
  assign go  = !stall && !asleep;

  zt_sleep_sync #(.STAGES(SLEEP_STAGES)) u_sleep (
    .clk(clk), .rst(rst), .sleep(sleep), .asleep(asleep)
  );

  zt_cmd_front #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)) u_front (
    .clk(clk), .rst(rst), .go(go), .sel(sel), .burst_cont(burst_cont),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .order_xor(order_xor), .addr(addr),
    .iss_op(s1_op), .iss_addr(s1_addr), .iss_be_n(s1_be_n)
  );

  zt_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
    .clk(clk), .rst(rst), .go(go), .s1_op(s1_op), .s1_addr(s1_addr),
    .s1_be_n(s1_be_n), .din(din), .rd_vld(rd_vld), .rd_data(dout)
  );

  assign dout_en = rd_vld && !oe_n && !asleep;
endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst,
  input logic         stall,
  input logic         oe_n,
  input logic         sleep,
  input logic [W-1:0] dout,
  input logic         dout_en
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !dout_en);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(dout));

  a_r10_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    (sleep && $past(sleep) && !$past(rst)) |=> !dout_en);
endmodule

bind zt_burst_sram zt_burst_sram_chk #(.W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .oe_n(oe_n), .sleep(sleep),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/zt_burst_sram_bench.sv
`timescale 1ns/1ps
module zt_burst_sram_bench;
  localparam logic [2:0] SEL = 3'b010;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, stall = 1'b0, burst_cont = 1'b0, wr_n = 1'b1;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic        order_xor = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [7:0]  addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_en;

  zt_burst_sram u_zt_burst_sram (
    .clk(clk), .rst(rst), .stall(stall), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .order_xor(order_xor), .oe_n(oe_n), .sleep(sleep), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  int n_cmp = 0, n_bad = 0;

  // behavioural reference
  logic [35:0] rmem [256];
  logic        b_act, b_wr, bs1, bs2;
  logic [7:0]  b_base;
  int          b_cnt;
  int          p1_op, p2_op;           // 0 none, 1 read, 2 write
  logic [7:0]  p1_a, p2_a;
  logic [3:0]  p1_be, p2_be;
  logic        exp_vld;
  logic [35:0] exp_dout;

  task automatic model_edge();
    if (rst) begin
      b_act = 0; bs1 = 0; bs2 = 0; p1_op = 0; p2_op = 0; exp_vld = 0;
    end else begin
      if (!stall && !bs2) begin
        if (p2_op == 1) begin exp_vld = 1; exp_dout = rmem[p2_a]; end
        else exp_vld = 0;
        if (p2_op == 2)
          for (int l = 0; l < 4; l++)
            if (!p2_be[l]) rmem[p2_a][l*9 +: 9] = din[l*9 +: 9];
        p2_op = p1_op; p2_a = p1_a; p2_be = p1_be;
        p1_be = lane_wr_n;
        if (!burst_cont) begin
          if ({sel_a_n, sel_b, sel_c_n} == SEL) begin
            b_act = 1; b_wr = !wr_n; b_base = addr; b_cnt = 0;
            p1_op = wr_n ? 1 : 2; p1_a = addr;
          end else begin
            b_act = 0; p1_op = 0;
          end
        end else if (b_act) begin
          b_cnt = (b_cnt + 1) % 4;
          p1_op = b_wr ? 2 : 1;
          p1_a[7:2] = b_base[7:2];
          p1_a[1:0] = order_xor ? (b_base[1:0] ^ 2'(b_cnt)) : 2'(b_base[1:0] + 2'(b_cnt));
        end else p1_op = 0;
      end
      bs2 = bs1; bs1 = sleep;
    end
  endtask

  task automatic step(input string tag);
    logic exp_en;
    @(posedge clk);
    model_edge();
    #1;
    exp_en = exp_vld && !oe_n && !bs2;
    n_cmp++;
    if (dout_en !== exp_en) begin
      n_bad++;
      $display("FAIL %s dout_en actual %b expected %b at %0t", tag, dout_en, exp_en, $time);
    end else if (exp_en) begin
      n_cmp++;
      if (dout !== exp_dout) begin
        n_bad++;
        $display("FAIL %s dout actual %h expected %h at %0t", tag, dout, exp_dout, $time);
      end
    end
  endtask

  task automatic drive(input logic cont, input logic [2:0] ce, input logic wn,
                       input logic [3:0] ln, input logic [7:0] a);
    burst_cont = cont; {sel_a_n, sel_b, sel_c_n} = ce; wr_n = wn;
    lane_wr_n = ln; addr = a; din = {$urandom, $urandom};
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin drive(0, 3'b110, 1, 4'hF, 0); step(tag); end
  endtask

  task automatic burst4(input logic wn, input logic [3:0] ln, input logic [7:0] a,
                        input string tag);
    drive(0, SEL, wn, ln, a); step(tag);
    for (int i = 0; i < 3; i++) begin drive(1, SEL, 1, ln, 8'hFF); step(tag); end
  endtask

  initial begin
    #1;
    step("R1"); step("R1");
    rst = 1'b0;
    idle(2, "R1");
    // fill
    for (int i = 0; i < 256; i++) begin drive(0, SEL, 0, 4'h0, 8'(i)); step("R2"); end
    // read/write alternating with no gap
    for (int i = 0; i < 24; i++) begin
      drive(0, SEL, i[0], 4'h0, 8'(i * 7)); step("R2");
    end
    idle(3, "R2");
    // lane strobes and abort
    drive(0, SEL, 0, 4'b1010, 8'h20); step("R3");
    drive(0, SEL, 0, 4'b1111, 8'h21); step("R3");
    drive(0, SEL, 0, 4'b0111, 8'h22); step("R3");
    idle(2, "R3");
    for (int i = 0; i < 3; i++) begin drive(0, SEL, 1, 4'hF, 8'(8'h20 + i)); step("R3"); end
    idle(3, "R3");
    // forwarding: write then immediate read of same address
    for (int i = 0; i < 6; i++) begin
      drive(0, SEL, 0, 4'(i * 5), 8'h40 + 8'(i)); step("R4");
      drive(0, SEL, 1, 4'hF, 8'h40 + 8'(i)); step("R4");
    end
    idle(3, "R4");
    // interleaved bursts
    order_xor = 1'b1;
    burst4(0, 4'h0, 8'h51, "R5"); burst4(1, 4'hF, 8'h51, "R5");
    burst4(1, 4'hF, 8'h56, "R5"); idle(3, "R5");
    // linear bursts
    order_xor = 1'b0;
    burst4(0, 4'h0, 8'h62, "R6"); burst4(1, 4'hF, 8'h61, "R6");
    burst4(1, 4'hF, 8'h63, "R6"); idle(3, "R6");
    order_xor = 1'b1;
    // select decode
    for (int c = 0; c < 8; c++) begin
      drive(0, 3'(c), 0, 4'h0, 8'h70); step("R7");
      drive(0, SEL, 1, 4'hF, 8'h70); step("R7");
    end
    idle(3, "R7");
    // continue after deselect
    drive(0, 3'b110, 1, 4'hF, 8'h10); step("R8");
    for (int i = 0; i < 4; i++) begin drive(1, SEL, 0, 4'h0, 8'h10); step("R8"); end
    idle(2, "R8");
    drive(0, SEL, 1, 4'hF, 8'h10); step("R8"); idle(3, "R8");
    // stalls inside bursts
    for (int i = 0; i < 20; i++) begin
      stall = i[1];
      drive(i % 4 != 0, SEL, i[3], 4'(i), 8'h80 + 8'(i)); step("R9");
    end
    stall = 0; idle(3, "R9");
    // output enable
    for (int i = 0; i < 12; i++) begin
      oe_n = i[0];
      drive(0, SEL, 1, 4'hF, 8'(i)); step("R10");
    end
    oe_n = 0; idle(3, "R10");
    // sleep
    drive(0, SEL, 1, 4'hF, 8'h05); step("R11");
    sleep = 1;
    for (int i = 0; i < 6; i++) begin drive(0, SEL, i[0], 4'h0, 8'h30); step("R11"); end
    sleep = 0;
    for (int i = 0; i < 3; i++) begin drive(0, SEL, 1, 4'hF, 8'h30); step("R11"); end
    idle(3, "R11");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      stall = ($urandom % 10) == 0;
      oe_n  = ($urandom % 12) == 0;
      if (i % 500 == 0) order_xor = $urandom;
      drive(($urandom % 3) == 0, (($urandom % 8) == 0) ? 3'($urandom) : SEL,
            $urandom, 4'($urandom), 8'($urandom % 32)); step("R2");
    end
    stall = 0; oe_n = 0; idle(3, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule